// File: doc/BRIEF.md
# CAN Transmit Mailbox Status Register

This block holds the per-mailbox transmit status and abort control for three transmit mailboxes of a CAN controller. A transmit engine reports how each send attempt ended (success, lost arbitration, bus error) and when an abort has finished. It also reports whether each mailbox is idle or holds a pending message, and it pulses a per-mailbox strobe whenever a new transmit request is posted. Software sees all of this as one 32-bit word with one 8-bit lane per mailbox.

Software acknowledges a finished request by writing one to its completion flag. That write also wipes the mailbox's outcome flags. Software cancels a queued send by writing one to the abort bit. The abort bit is taken only while a message is pending, and it is driven out to the engine until the mailbox drops to idle.

Top module: `can_tx_status`

## Requirements
- R1: After reset, every bit of `rdData` reads 0 and `abortReq` is 0.
- R2: Mailbox n uses bits 8n+7..8n. Within the lane, bit 7 is abort, bit 3 is transmit error, bit 2 is arbitration lost, bit 1 is transmit OK and bit 0 is completion. Bits 6:4 of each lane, and bits 31:24, read 0 and ignore writes.
- R3: Any completion event for a mailbox (success, arbitration loss, error or abort finished) sets its completion bit on the next clock.
- R4: A success event sets transmit OK to 1. An arbitration-loss or error event sets it to 0. An abort-finished event leaves it unchanged.
- R5: An arbitration-loss event sets the arbitration-lost bit and an error event sets the transmit-error bit. Each stays set until the completion bit is cleared.
- R6: A write with bit 0 of a lane at 1 clears that lane's completion, OK, arbitration-lost and error bits on the same clock. A 0 in that position has no effect.
- R7: A transmit-request-set pulse for a mailbox clears the same four bits of that mailbox on the same clock.
- R8: When a completion event and a clear hit a mailbox in the same cycle, the event wins. Completion ends at 1, and only the event's outcome bits are set, applied over a cleared lane.
- R9: Writes to bits 1, 2 and 3 of a lane have no effect.
- R10: A write with bit 7 of a lane at 1 sets that mailbox's abort bit when the mailbox is pending and not idle. `abortReq[n]` equals that bit.
- R11: A write of 1 to the abort bit of a mailbox that is not pending has no effect.
- R12: While a mailbox is idle, its abort bit is cleared on the next clock. Idle takes priority over a simultaneous write of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data |
| evtOk | input | 3 | Per-mailbox pulse: send attempt succeeded |
| evtArbLost | input | 3 | Per-mailbox pulse: send lost arbitration |
| evtError | input | 3 | Per-mailbox pulse: send failed with bus error |
| evtAbortDone | input | 3 | Per-mailbox pulse: abort finished |
| mboxIdle | input | 3 | Per-mailbox level: mailbox idle |
| mboxPending | input | 3 | Per-mailbox level: message waiting to be sent |
| txReqSet | input | 3 | Per-mailbox pulse: new transmit request posted |
| abortReq | output | 3 | Per-mailbox abort request to the engine |

## Verification
Each outcome event is applied to a different mailbox, and the lanes are chained so that a later success over earlier failures shows that OK is overwritten while the failure flags are held. This also confirms that each lane moves without disturbing its neighbours. Write patterns that set only the read-only, reserved or zero bits are separated from write-one acknowledgements and transmit-request pulses, and each is sent both alone and in the same cycle as a completion event to expose the priority. The abort bit is written with the mailbox not pending, then pending, then pending and idle together, which separates the acceptance gate from the idle-driven removal.

// File: rtl/can_tx_status_pkg.sv
package can_tx_status_pkg;
  localparam int CMP_POS = 0;
  localparam int OK_POS  = 1;
  localparam int ARB_POS = 2;
  localparam int ERR_POS = 3;
  localparam int ABT_POS = 7;

  typedef struct packed {
    logic clrOutcome;
    logic setCmp;
    logic sendDone;
    logic okVal;
    logic setArb;
    logic setErr;
    logic setAbort;
    logic clrAbort;
  } laneStb_t;
endpackage

// File: rtl/can_tx_status_ctrl.sv
module can_tx_status_ctrl
  import can_tx_status_pkg::*;
#(
  parameter int NUM_MBOX = 3,
  parameter int LANE_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_MBOX-1:0] evtOk,
  input  logic [NUM_MBOX-1:0] evtArbLost,
  input  logic [NUM_MBOX-1:0] evtError,
  input  logic [NUM_MBOX-1:0] evtAbortDone,
  input  logic [NUM_MBOX-1:0] mboxIdle,
  input  logic [NUM_MBOX-1:0] mboxPending,
  input  logic [NUM_MBOX-1:0] txReqSet,
  output laneStb_t            stb [NUM_MBOX]
);
  logic unusedWrBits;
  assign unusedWrBits = ^wrData;

  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_lane
    localparam int BASE = i * LANE_W;
    always_comb begin
      stb[i].sendDone   = evtOk[i] | evtArbLost[i] | evtError[i];
      stb[i].setCmp     = stb[i].sendDone | evtAbortDone[i];
      stb[i].okVal      = evtOk[i];
      stb[i].setArb     = evtArbLost[i];
      stb[i].setErr     = evtError[i];
      stb[i].clrOutcome = txReqSet[i] | (wrEn & wrData[BASE+CMP_POS]);
      stb[i].setAbort   = wrEn & wrData[BASE+ABT_POS] & mboxPending[i];
      stb[i].clrAbort   = mboxIdle[i];
    end
  end
endmodule

// File: rtl/can_tx_status_data.sv
module can_tx_status_data
  import can_tx_status_pkg::*;
#(
  parameter int NUM_MBOX = 3,
  parameter int LANE_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  laneStb_t            stb [NUM_MBOX],
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_MBOX-1:0] abortReq
);
  logic [NUM_MBOX-1:0] cmpQ, okQ, arbQ, errQ, abtQ;

  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpQ[i] <= 1'b0;
        okQ[i]  <= 1'b0;
        arbQ[i] <= 1'b0;
        errQ[i] <= 1'b0;
        abtQ[i] <= 1'b0;
      end else begin
        cmpQ[i] <= (cmpQ[i] & ~stb[i].clrOutcome) | stb[i].setCmp;
        okQ[i]  <= stb[i].sendDone ? stb[i].okVal : (okQ[i] & ~stb[i].clrOutcome);
        arbQ[i] <= (arbQ[i] & ~stb[i].clrOutcome) | stb[i].setArb;
        errQ[i] <= (errQ[i] & ~stb[i].clrOutcome) | stb[i].setErr;
        abtQ[i] <= stb[i].clrAbort ? 1'b0 : (abtQ[i] | stb[i].setAbort);
      end
    end

    // R5: an outcome flag never stands without completion
    a_r5_outcome_needs_cmp: assert property (@(posedge clk) disable iff (!rstN)
      (okQ[i] | arbQ[i] | errQ[i]) |-> cmpQ[i]);
    // R3: any completion event leaves completion set
    a_r3_event_sets_cmp: assert property (@(posedge clk) disable iff (!rstN)
      stb[i].setCmp |=> cmpQ[i]);
    // R6: a clear with no event empties the lane
    a_r6_clear_wipes: assert property (@(posedge clk) disable iff (!rstN)
      (stb[i].clrOutcome && !stb[i].setCmp) |=> !(cmpQ[i] | okQ[i] | arbQ[i] | errQ[i]));
    // R10: abort only rises after an accepted write
    a_r10_abort_gated: assert property (@(posedge clk) disable iff (!rstN)
      $rose(abtQ[i]) |-> $past(stb[i].setAbort));
    // R12: idle removes abort
    a_r12_idle_drops_abort: assert property (@(posedge clk) disable iff (!rstN)
      stb[i].clrAbort |=> !abtQ[i]);
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_MBOX; i++) begin
      rdData[i*LANE_W+CMP_POS] = cmpQ[i];
      rdData[i*LANE_W+OK_POS]  = okQ[i];
      rdData[i*LANE_W+ARB_POS] = arbQ[i];
      rdData[i*LANE_W+ERR_POS] = errQ[i];
      rdData[i*LANE_W+ABT_POS] = abtQ[i];
    end
  end

  assign abortReq = abtQ;
endmodule

// File: rtl/can_tx_status.sv
module can_tx_status
  import can_tx_status_pkg::*;
#(
  parameter int NUM_MBOX = 3,
  parameter int LANE_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_MBOX-1:0] evtOk,
  input  logic [NUM_MBOX-1:0] evtArbLost,
  input  logic [NUM_MBOX-1:0] evtError,
  input  logic [NUM_MBOX-1:0] evtAbortDone,
  input  logic [NUM_MBOX-1:0] mboxIdle,
  input  logic [NUM_MBOX-1:0] mboxPending,
  input  logic [NUM_MBOX-1:0] txReqSet,
  output logic [NUM_MBOX-1:0] abortReq
);
  laneStb_t stb [NUM_MBOX];

  can_tx_status_ctrl #(.NUM_MBOX(NUM_MBOX), .LANE_W(LANE_W), .DATA_W(DATA_W)) u_ctrl (
    .wrEn(wrEn), .wrData(wrData), .evtOk(evtOk), .evtArbLost(evtArbLost),
    .evtError(evtError), .evtAbortDone(evtAbortDone), .mboxIdle(mboxIdle),
    .mboxPending(mboxPending), .txReqSet(txReqSet), .stb(stb)
  );

  can_tx_status_data #(.NUM_MBOX(NUM_MBOX), .LANE_W(LANE_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .rdData(rdData), .abortReq(abortReq)
  );
endmodule

// File: tb/can_tx_status_bench.sv
module can_tx_status_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [2:0]  evtOk = '0, evtArbLost = '0, evtError = '0, evtAbortDone = '0;
  logic [2:0]  mboxIdle = '0, mboxPending = '0, txReqSet = '0;
  logic [2:0]  abortReq;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  can_tx_status u_can_tx_status (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .evtOk(evtOk), .evtArbLost(evtArbLost), .evtError(evtError),
    .evtAbortDone(evtAbortDone), .mboxIdle(mboxIdle), .mboxPending(mboxPending),
    .txReqSet(txReqSet), .abortReq(abortReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle of pulses after a falling edge; returns at the next falling edge
  task automatic pulse(input logic wr, input logic [31:0] d, input logic [2:0] ok,
                       input logic [2:0] arb, input logic [2:0] err,
                       input logic [2:0] abd, input logic [2:0] req);
    wrEn = wr; wrData = d; evtOk = ok; evtArbLost = arb; evtError = err;
    evtAbortDone = abd; txReqSet = req;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; evtOk = '0; evtArbLost = '0; evtError = '0;
    evtAbortDone = '0; txReqSet = '0;
  endtask

  task automatic tReset;
    chk("R1 rdData", rdData, 32'h0);
    chk("R1 abortReq", {29'h0, abortReq}, 32'h0);
  endtask

  task automatic tSuccess;
    pulse(1'b0, 32'h0, 3'b001, 3'b0, 3'b0, 3'b0, 3'b0);
    chk("R3 R4 success lane0", rdData, 32'h0000_0003);
  endtask

  task automatic tWriteOne;
    pulse(1'b1, 32'h0, 3'b0, 3'b0, 3'b0, 3'b0, 3'b0);
    chk("R6 zero write", rdData, 32'h0000_0003);
    pulse(1'b1, 32'hFF7E_7E7E, 3'b0, 3'b0, 3'b0, 3'b0, 3'b0);
    chk("R9 R2 readonly and reserved", rdData, 32'h0000_0003);
    pulse(1'b1, 32'h0000_0001, 3'b0, 3'b0, 3'b0, 3'b0, 3'b0);
    chk("R6 w1c clear", rdData, 32'h0);
  endtask

  task automatic tFailures;
    pulse(1'b0, 32'h0, 3'b0, 3'b010, 3'b0, 3'b0, 3'b0);
    chk("R5 arb lane1", rdData, 32'h0000_0500);
    pulse(1'b0, 32'h0, 3'b0, 3'b0, 3'b010, 3'b0, 3'b0);
    chk("R5 err lane1 arb held", rdData, 32'h0000_0D00);
    pulse(1'b0, 32'h0, 3'b010, 3'b0, 3'b0, 3'b0, 3'b0);
    chk("R4 ok over failures", rdData, 32'h0000_0F00);
    pulse(1'b0, 32'h0, 3'b100, 3'b0, 3'b0, 3'b0, 3'b0);
    chk("R2 lane2 ok", rdData, 32'h0003_0F00);
    pulse(1'b0, 32'h0, 3'b0, 3'b0, 3'b100, 3'b0, 3'b0);
    chk("R4 err zeroes ok", rdData, 32'h0009_0F00);
  endtask

  task automatic tTxReq;
    pulse(1'b0, 32'h0, 3'b0, 3'b0, 3'b0, 3'b0, 3'b010);
    chk("R7 txreq clear lane1", rdData, 32'h0009_0000);
  endtask

  task automatic tAbortDone;
    pulse(1'b0, 32'h0, 3'b0, 3'b0, 3'b0, 3'b001, 3'b0);
    chk("R3 abort done lane0", rdData, 32'h0009_0001);
    pulse(1'b0, 32'h0, 3'b100, 3'b0, 3'b0, 3'b0, 3'b0);
    pulse(1'b0, 32'h0, 3'b0, 3'b0, 3'b0, 3'b100, 3'b0);
    chk("R4 abort done keeps ok", rdData, 32'h000B_0001);
    pulse(1'b0, 32'h0, 3'b0, 3'b0, 3'b100, 3'b0, 3'b0);
    chk("R4 err after ok", rdData, 32'h0009_0001);
  endtask

  task automatic tCollide;
    pulse(1'b0, 32'h0, 3'b0, 3'b100, 3'b0, 3'b0, 3'b100);
    chk("R8 txreq with arb", rdData, 32'h0005_0001);
    pulse(1'b1, 32'h0000_0001, 3'b001, 3'b0, 3'b0, 3'b0, 3'b0);
    chk("R8 w1c with ok", rdData, 32'h0005_0003);
  endtask

  task automatic tAbort;
    pulse(1'b1, 32'h0000_0080, 3'b0, 3'b0, 3'b0, 3'b0, 3'b0);
    chk("R11 abort not pending", rdData, 32'h0005_0003);
    chk("R11 abortReq", {29'h0, abortReq}, 32'h0);
    mboxPending = 3'b101;
    pulse(1'b1, 32'h0000_0080, 3'b0, 3'b0, 3'b0, 3'b0, 3'b0);
    chk("R10 abort accepted", rdData, 32'h0005_0083);
    chk("R10 abortReq", {29'h0, abortReq}, 32'h1);
    pulse(1'b1, 32'h0000_0000, 3'b0, 3'b0, 3'b0, 3'b0, 3'b0);
    chk("R10 abort held", {29'h0, abortReq}, 32'h1);
    pulse(1'b1, 32'h0080_0000, 3'b0, 3'b0, 3'b0, 3'b0, 3'b0);
    chk("R10 abort lane2", {29'h0, abortReq}, 32'h5);
    mboxIdle = 3'b001;
    mboxPending = 3'b100;
    @(posedge clk);
    @(negedge clk);
    chk("R12 idle clears", rdData, 32'h0085_0003);
    mboxPending = 3'b101;
    pulse(1'b1, 32'h0000_0080, 3'b0, 3'b0, 3'b0, 3'b0, 3'b0);
    chk("R12 idle beats set", {29'h0, abortReq}, 32'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSuccess();
    tWriteOne();
    tFailures();
    tTxReq();
    tAbortDone();
    tCollide();
    tAbort();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule